// File: doc/BRIEF.md
# LED Controller Configuration Register Bank with I2C Target

This block is the host-facing configuration store of a six-channel LED controller. A two-wire serial host reaches it as a bus target. The 7-bit device address has its upper five bits fixed at `11101`. Its two low bits come from a four-way strap. Register accesses use one pointer byte followed by single or burst writes, and the pointer steps forward after each byte. Reads use a repeated START and can also run as a burst.

Three register families are double-buffered: per-channel colour levels, 12-bit PWM duty words, and the three pattern timing sets. A host write lands in a staging copy. The value reaches the drive logic only after the host writes the commit key to that family's update register. One frequency-trim register is guarded by a single-use unlock key. A key write to a reset register returns the whole map to defaults. A rising edge on the shutdown input returns the bus engine to idle and keeps every stored value.

The whole active register image is presented on one flat output, with one byte per register address. The pad drivers and the analogue current path sit outside this block.

Top module: `led_cfg_i2c`

## Requirements
- R1: The target acknowledges an address byte whose upper seven bits equal `11101` followed by the strap code. The strap code `strap_i` is 0 for a ground tie, 1 for a clock-line tie, 2 for a data-line tie and 3 for a supply tie. Bit 0 of the address byte is the direction: 0 write, 1 read.
- R2: After a non-matching address the target leaves the data line released (NACK) until the next START. Data bytes sent in that transaction change no register.
- R3: In a write transaction the first byte after the address sets the register pointer. Each later byte is stored at the pointer, and the pointer then advances by one.
- R4: A read is a pointer write, a repeated START and a read address. Bytes are returned MSB first from consecutive addresses. A double-buffered register reads back its staging value.
- R5: Register 00h is read-only and returns the target's write address byte, `{11101, strap, 0}` (E8h, EAh, ECh or EEh).
- R6: Writing C5h commits a family's staging copies to the active outputs. Address 52h commits colours 10h–15h, 20h–25h and 30h–35h. Address 53h commits PWM 40h–4Bh. Addresses 54h, 55h and 56h commit pattern timing x9h–xFh of pattern 1, 2 or 3 respectively. Any other family is untouched. Byte `a` of `active_regs_o` is bits `8a+7:8a`.
- R7: A value other than the key, written to 0Bh, 52h–56h or 5Fh, has no effect. These write-only addresses read 00h.
- R8: Register 0Ch takes a write only when A5h was written to 0Bh beforehand. The next write to 0Ch uses up the unlock, whether or not it stores.
- R9: Writing C5h to 5Fh restores every staging and active register to its default and locks 0Ch again.
- R10: After reset, 02h reads 1Fh, 03h reads 01h, 07h reads 3Fh and each of 1Ch, 2Ch and 3Ch reads 01h. All other registers read 00h.
- R11: A STOP or START that arrives before the ninth clock of a data byte abandons that byte without storing any part of it. The following transaction works normally.
- R12: A rising edge on `shdn_n_i` returns the bus engine to idle and releases the data line. All register contents are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; bus lines are oversampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe_o | output | 1 | Pull data line low when 1 (ACK or read 0) |
| strap_i | input | 2 | Decoded address strap state, code per R1 |
| shdn_n_i | input | 1 | Shutdown pin; rising edge resets the bus engine |
| active_regs_o | output | 768 | Active image, one byte per register address 00h–5Fh |

## Verification
Each bus line passes two synchroniser flops and one edge-detect flop before the engine acts, so the target drives or releases the data line three clock cycles after the serial-clock edge that causes it. A stored byte appears on `active_regs_o` one cycle after the falling edge that ends its eighth bit, and a commit appears one cycle after the key byte is taken. The bench holds each bus phase for ten clocks. It samples ACK and read data halfway through the serial-clock high phase, and reads the active image only after the STOP. Each value it checks is therefore settled at least several cycles before it is sampled.

// File: rtl/led_cfg_pkg.sv
package led_cfg_pkg;

  localparam int NREG = 96;
  localparam int IW   = $clog2(NREG);

  localparam logic [7:0] KEY_COMMIT = 8'hC5;
  localparam logic [7:0] KEY_UNLOCK = 8'hA5;

  localparam logic [7:0] A_ID       = 8'h00;
  localparam logic [7:0] A_UNLOCK   = 8'h0B;
  localparam logic [7:0] A_TRIM     = 8'h0C;
  localparam logic [7:0] A_SOFTRST  = 8'h5F;

  typedef enum logic [2:0] {
    G_NONE, G_COLOR, G_PWM, G_PAT1, G_PAT2, G_PAT3
  } grp_e;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AACK, S_WDATA, S_WACK, S_RDATA, S_RACK
  } bus_state_e;

  // Double-buffered family an address belongs to
  function automatic grp_e reg_group(input logic [7:0] a);
    grp_e g;
    g = G_NONE;
    if (a[7:4] >= 4'h1 && a[7:4] <= 4'h3) begin
      if (a[3:0] <= 4'h5) g = G_COLOR;
      else if (a[3:0] >= 4'h9) begin
        case (a[7:4])
          4'h1:    g = G_PAT1;
          4'h2:    g = G_PAT2;
          default: g = G_PAT3;
        endcase
      end
    end else if (a >= 8'h40 && a <= 8'h4B) begin
      g = G_PWM;
    end
    return g;
  endfunction

  function automatic logic has_shadow(input logic [7:0] a);
    return reg_group(a) != G_NONE;
  endfunction

  // Family selected by a key write to an update address
  function automatic grp_e update_target(input logic [7:0] a);
    case (a)
      8'h52:   return G_COLOR;
      8'h53:   return G_PWM;
      8'h54:   return G_PAT1;
      8'h55:   return G_PAT2;
      8'h56:   return G_PAT3;
      default: return G_NONE;
    endcase
  endfunction

  // Addresses with single-copy storage
  function automatic logic is_plain(input logic [7:0] a);
    return (a >= 8'h01 && a <= 8'h05) || (a >= 8'h07 && a <= 8'h09) || (a == A_TRIM);
  endfunction

  function automatic logic is_stored(input logic [7:0] a);
    return is_plain(a) || has_shadow(a);
  endfunction

  function automatic logic [7:0] reg_default(input logic [7:0] a);
    case (a)
      8'h02:                   return 8'h1F;
      8'h03:                   return 8'h01;
      8'h07:                   return 8'h3F;
      8'h1C, 8'h2C, 8'h3C:     return 8'h01;
      default:                 return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync
  #(parameter int STAGES = 2)
  (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic shdn_n_i,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev,
  output logic proto_rst
);

  logic [STAGES-1:0] scl_s, sda_s, sd_s;
  logic scl_p, sda_p, sd_p;
  logic scl_h, sda_h, sd_h;

  assign scl_h = scl_s[STAGES-1];
  assign sda_h = sda_s[STAGES-1];
  assign sd_h  = sd_s[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= '1;
      sda_s <= '1;
      sd_s  <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
      sd_p  <= 1'b1;
    end else begin
      scl_s <= {scl_s[STAGES-2:0], scl_i};
      sda_s <= {sda_s[STAGES-2:0], sda_i};
      sd_s  <= {sd_s[STAGES-2:0], shdn_n_i};
      scl_p <= scl_h;
      sda_p <= sda_h;
      sd_p  <= sd_h;
    end
  end

  assign sda_q     = sda_h;
  assign scl_rise  = scl_h & ~scl_p;
  assign scl_fall  = ~scl_h & scl_p;
  assign start_ev  = scl_h & scl_p & sda_p & ~sda_h;
  assign stop_ev   = scl_h & scl_p & ~sda_p & sda_h;
  assign proto_rst = sd_h & ~sd_p;

endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import led_cfg_pkg::*;
  (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       proto_rst,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_ev,
  input  logic       stop_ev,
  input  logic       sda_q,
  input  logic [6:0] dev_addr,
  input  logic [7:0] rd_data,
  output logic       sda_oe,
  output logic       wr_en,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  output logic [7:0] rd_addr
);

  bus_state_e state_q;
  logic [3:0] cnt_q;
  logic [7:0] sh_q;
  logic [7:0] ptr_q;
  logic       ptr_pend_q;
  logic       rw_q;
  logic       mack_q;
  logic       oe_q;
  logic       wr_en_q;
  logic [7:0] wr_addr_q, wr_data_q;
  logic       byte_full;
  logic       addr_hit;

  assign byte_full = (cnt_q == 4'd8);
  assign addr_hit  = (sh_q[7:1] == dev_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      cnt_q      <= '0;
      sh_q       <= '0;
      ptr_q      <= '0;
      ptr_pend_q <= 1'b0;
      rw_q       <= 1'b0;
      mack_q     <= 1'b0;
      oe_q       <= 1'b0;
      wr_en_q    <= 1'b0;
      wr_addr_q  <= '0;
      wr_data_q  <= '0;
    end else begin
      wr_en_q <= 1'b0;
      if (proto_rst) begin
        state_q <= S_IDLE;
        oe_q    <= 1'b0;
      end else if (start_ev) begin
        state_q <= S_ADDR;
        cnt_q   <= '0;
        oe_q    <= 1'b0;
      end else if (stop_ev) begin
        state_q <= S_IDLE;
        oe_q    <= 1'b0;
      end else begin
        case (state_q)
          S_ADDR: begin
            if (scl_rise && !byte_full) begin
              sh_q  <= {sh_q[6:0], sda_q};
              cnt_q <= cnt_q + 4'd1;
            end else if (scl_fall && byte_full) begin
              if (addr_hit) begin
                rw_q    <= sh_q[0];
                oe_q    <= 1'b1;
                state_q <= S_AACK;
              end else begin
                oe_q    <= 1'b0;
                state_q <= S_IDLE;
              end
            end
          end
          S_AACK: begin
            if (scl_fall) begin
              if (rw_q) begin
                sh_q    <= rd_data;
                oe_q    <= ~rd_data[7];
                cnt_q   <= 4'd1;
                state_q <= S_RDATA;
              end else begin
                oe_q       <= 1'b0;
                cnt_q      <= '0;
                ptr_pend_q <= 1'b1;
                state_q    <= S_WDATA;
              end
            end
          end
          S_WDATA: begin
            if (scl_rise && !byte_full) begin
              sh_q  <= {sh_q[6:0], sda_q};
              cnt_q <= cnt_q + 4'd1;
            end else if (scl_fall && byte_full) begin
              if (ptr_pend_q) begin
                ptr_q      <= sh_q;
                ptr_pend_q <= 1'b0;
              end else begin
                wr_en_q   <= 1'b1;
                wr_addr_q <= ptr_q;
                wr_data_q <= sh_q;
                ptr_q     <= ptr_q + 8'd1;
              end
              oe_q    <= 1'b1;
              state_q <= S_WACK;
            end
          end
          S_WACK: begin
            if (scl_fall) begin
              oe_q    <= 1'b0;
              cnt_q   <= '0;
              state_q <= S_WDATA;
            end
          end
          S_RDATA: begin
            if (scl_fall) begin
              if (byte_full) begin
                oe_q    <= 1'b0;
                ptr_q   <= ptr_q + 8'd1;
                state_q <= S_RACK;
              end else begin
                oe_q  <= ~sh_q[6];
                sh_q  <= {sh_q[6:0], 1'b0};
                cnt_q <= cnt_q + 4'd1;
              end
            end
          end
          S_RACK: begin
            if (scl_rise) begin
              mack_q <= ~sda_q;
            end else if (scl_fall) begin
              if (mack_q) begin
                sh_q    <= rd_data;
                oe_q    <= ~rd_data[7];
                cnt_q   <= 4'd1;
                state_q <= S_RDATA;
              end else begin
                state_q <= S_IDLE;
              end
            end
          end
          default: begin
            oe_q <= 1'b0;
          end
        endcase
      end
    end
  end

  assign sda_oe  = oe_q;
  assign wr_en   = wr_en_q;
  assign wr_addr = wr_addr_q;
  assign wr_data = wr_data_q;
  assign rd_addr = ptr_q;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE) |-> !oe_q); // R2

  AST_WRITE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_q |-> $past(scl_fall)); // R11

  AST_NO_WRITE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !wr_en_q); // R11

  AST_PROTO_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    proto_rst |=> (state_q == S_IDLE && !oe_q)); // R12

endmodule

// File: rtl/led_reg_bank.sv
module led_reg_bank
  import led_cfg_pkg::*;
  (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [7:0]        rd_addr,
  input  logic [7:0]        dev_id,
  output logic [7:0]        rd_data,
  output logic [NREG*8-1:0] active_o
);

  logic [7:0] sh_q  [NREG];
  logic [7:0] act_q [NREG];
  logic       unlock_q;

  logic key_write, soft_rst, unlock_set, trim_wr, store_ok;
  grp_e commit_grp;

  assign key_write  = wr_en && (wr_data == KEY_COMMIT);
  assign commit_grp = key_write ? update_target(wr_addr) : G_NONE;
  assign soft_rst   = key_write && (wr_addr == A_SOFTRST);
  assign unlock_set = wr_en && (wr_addr == A_UNLOCK) && (wr_data == KEY_UNLOCK);
  assign trim_wr    = wr_en && (wr_addr == A_TRIM);
  assign store_ok   = wr_en && is_stored(wr_addr) && ((wr_addr != A_TRIM) || unlock_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlock_q <= 1'b0;
      for (int i = 0; i < NREG; i++) begin
        sh_q[i]  <= reg_default(8'(i));
        act_q[i] <= reg_default(8'(i));
      end
    end else if (soft_rst) begin
      unlock_q <= 1'b0;
      for (int i = 0; i < NREG; i++) begin
        sh_q[i]  <= reg_default(8'(i));
        act_q[i] <= reg_default(8'(i));
      end
    end else begin
      if (unlock_set)   unlock_q <= 1'b1;
      else if (trim_wr) unlock_q <= 1'b0;
      for (int i = 0; i < NREG; i++) begin
        if (store_ok && (wr_addr == 8'(i))) sh_q[i] <= wr_data;
        if ((commit_grp != G_NONE) && (reg_group(8'(i)) == commit_grp)) act_q[i] <= sh_q[i];
      end
    end
  end

  always_comb begin
    if (rd_addr == A_ID)                           rd_data = dev_id;
    else if (is_stored(rd_addr) && (rd_addr < 8'(NREG))) rd_data = sh_q[rd_addr[IW-1:0]];
    else                                           rd_data = 8'h00;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_view
    if (has_shadow(8'(g))) begin : g_dbl
      assign active_o[g*8 +: 8] = act_q[g];
    end else begin : g_sgl
      assign active_o[g*8 +: 8] = sh_q[g];
    end
  end

  logic [7:0] trim_view, col_sh_view, col_act_view, def02_view, def1c_view;
  assign trim_view    = sh_q[12];
  assign col_sh_view  = sh_q[16];
  assign col_act_view = act_q[16];
  assign def02_view   = sh_q[2];
  assign def1c_view   = act_q[28];

  AST_TRIM_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (trim_wr && !unlock_q) |=> $stable(trim_view)); // R8

  AST_UNLOCK_USED: assert property (@(posedge clk) disable iff (!rst_n)
    trim_wr |=> !unlock_q); // R8

  AST_COLOR_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_grp == G_COLOR) |=> (col_act_view == $past(col_sh_view))); // R6

  AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_grp == G_NONE && !soft_rst) |=> $stable(col_act_view)); // R6

  AST_SOFT_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (def02_view == 8'h1F && def1c_view == 8'h01 && !unlock_q)); // R9

endmodule

// File: rtl/led_cfg_i2c.sv
module led_cfg_i2c
  import led_cfg_pkg::*;
  #(parameter int          SYNC_STAGES = 2,
    parameter logic [4:0]  ADDR_HI     = 5'b11101)
  (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [1:0]        strap_i,
  input  logic              shdn_n_i,
  output logic [NREG*8-1:0] active_regs_o
);

  logic       sda_q, scl_rise, scl_fall, start_ev, stop_ev, proto_rst;
  logic       wr_en;
  logic [7:0] wr_addr, wr_data, rd_addr, rd_data;
  logic [6:0] dev_addr;

  assign dev_addr = {ADDR_HI, strap_i};

  i2c_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .shdn_n_i  (shdn_n_i),
    .sda_q     (sda_q),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_ev  (start_ev),
    .stop_ev   (stop_ev),
    .proto_rst (proto_rst)
  );

  i2c_target_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .proto_rst (proto_rst),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_ev  (start_ev),
    .stop_ev   (stop_ev),
    .sda_q     (sda_q),
    .dev_addr  (dev_addr),
    .rd_data   (rd_data),
    .sda_oe    (sda_oe_o),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr)
  );

  led_reg_bank u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .dev_id   ({dev_addr, 1'b0}),
    .rd_data  (rd_data),
    .active_o (active_regs_o)
  );

endmodule

// File: tb/led_cfg_i2c_tb_top.sv
module led_cfg_i2c_tb_top;
  import led_cfg_pkg::*;

  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic shdn_n = 1'b1;
  logic [1:0] strap = 2'd0;
  wire  sda_oe;
  wire  [NREG*8-1:0] act_flat;
  wire  sda_bus = sda_m & ~sda_oe;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  led_cfg_i2c dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_i         (scl),
    .sda_i         (sda_bus),
    .sda_oe_o      (sda_oe),
    .strap_i       (strap),
    .shdn_n_i      (shdn_n),
    .active_regs_o (act_flat)
  );

  function automatic logic [7:0] actv(input int a);
    return act_flat[a*8 +: 8];
  endfunction

  function automatic logic [6:0] dev7();
    return {5'b11101, strap};
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic qtr();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qtr();
    scl = 1'b1;   qtr();
    sda_m = 1'b0; qtr();
    scl = 1'b0;   qtr();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qtr();
    scl = 1'b1;   qtr();
    sda_m = 1'b1; qtr();
  endtask

  task automatic put_bits(input logic [7:0] v, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = v[i]; qtr();
      scl = 1'b1;   qtr(); qtr();
      scl = 1'b0;   qtr();
    end
  endtask

  task automatic get_ack(output logic ack);
    sda_m = 1'b1; qtr();
    scl = 1'b1;   qtr();
    ack = ~sda_bus; qtr();
    scl = 1'b0;   qtr();
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    put_bits(b, 8);
    get_ack(ack);
  endtask

  task automatic get_byte(input logic nack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      qtr();
      scl = 1'b1; qtr();
      b[i] = sda_bus; qtr();
      scl = 1'b0; qtr();
    end
    sda_m = nack; qtr();
    scl = 1'b1;   qtr(); qtr();
    scl = 1'b0;   qtr();
    sda_m = 1'b1;
  endtask

  task automatic wr1(input logic [7:0] a, input logic [7:0] d);
    logic k1, k2, k3;
    bus_start();
    put_byte({dev7(), 1'b0}, k1);
    put_byte(a, k2);
    put_byte(d, k3);
    bus_stop();
    check("R1 write acknowledged", {7'd0, k1 & k2 & k3}, 8'd1);
  endtask

  task automatic rd1(input logic [7:0] a, output logic [7:0] d);
    logic k1, k2, k3;
    bus_start();
    put_byte({dev7(), 1'b0}, k1);
    put_byte(a, k2);
    bus_start();
    put_byte({dev7(), 1'b1}, k3);
    get_byte(1'b1, d);
    bus_stop();
    check("R4 read acknowledged", {7'd0, k1 & k2 & k3}, 8'd1);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R10 default 02h", actv(8'h02), 8'h1F);
    check("R10 default 03h", actv(8'h03), 8'h01);
    check("R10 default 07h", actv(8'h07), 8'h3F);
    check("R10 default 1Ch", actv(8'h1C), 8'h01);
    check("R10 default 2Ch", actv(8'h2C), 8'h01);
    check("R10 default 3Ch", actv(8'h3C), 8'h01);
    check("R10 default 10h", actv(8'h10), 8'h00);
    check("R10 idle data line released", {7'd0, sda_oe}, 8'd0);
    rd1(8'h03, d);
    check("R10 bus read 03h", d, 8'h01);
  endtask

  task automatic t_strap();
    logic [7:0] d;
    for (int s = 0; s < 4; s++) begin
      strap = 2'(s);
      qtr();
      rd1(8'h00, d);
      check("R1 R5 strap id byte", d, {5'b11101, 2'(s), 1'b0});
    end
    strap = 2'd0;
    qtr();
  endtask

  task automatic t_nack();
    logic k1, k2, k3;
    logic [7:0] d;
    bus_start();
    put_byte(8'hEA, k1);
    put_byte(8'h01, k2);
    put_byte(8'h5A, k3);
    bus_stop();
    check("R2 foreign address nacked", {7'd0, k1}, 8'd0);
    check("R2 data after nack not acked", {7'd0, k2 | k3}, 8'd0);
    check("R2 no write after nack", actv(8'h01), 8'h00);
    rd1(8'h01, d);
    check("R2 register unchanged", d, 8'h00);
  endtask

  task automatic t_burst();
    logic k;
    logic [7:0] d0, d1, d2;
    bus_start();
    put_byte(8'hE8, k);
    put_byte(8'h01, k);
    put_byte(8'h11, k);
    put_byte(8'h22, k);
    put_byte(8'h33, k);
    bus_stop();
    check("R3 burst byte 1", actv(8'h01), 8'h11);
    check("R3 burst byte 2", actv(8'h02), 8'h22);
    check("R3 burst byte 3", actv(8'h03), 8'h33);
    bus_start();
    put_byte(8'hE8, k);
    put_byte(8'h01, k);
    bus_start();
    put_byte(8'hE9, k);
    get_byte(1'b0, d0);
    get_byte(1'b0, d1);
    get_byte(1'b1, d2);
    bus_stop();
    check("R4 burst read 01h", d0, 8'h11);
    check("R4 burst read 02h", d1, 8'h22);
    check("R4 burst read 03h", d2, 8'h33);
  endtask

  task automatic t_commit();
    logic [7:0] d;
    wr1(8'h10, 8'hAB);
    wr1(8'h20, 8'hCD);
    check("R6 colour staged only", actv(8'h10), 8'h00);
    rd1(8'h10, d);
    check("R4 staging readback", d, 8'hAB);
    wr1(8'h52, 8'h11);
    check("R7 wrong key no commit", actv(8'h10), 8'h00);
    rd1(8'h52, d);
    check("R7 update reg reads zero", d, 8'h00);
    wr1(8'h52, 8'hC5);
    check("R6 colour 1 committed", actv(8'h10), 8'hAB);
    check("R6 colour 2 committed", actv(8'h20), 8'hCD);
    wr1(8'h40, 8'h5A);
    wr1(8'h4B, 8'h0F);
    check("R6 pwm staged only", actv(8'h40), 8'h00);
    wr1(8'h53, 8'hC5);
    check("R6 pwm 40h committed", actv(8'h40), 8'h5A);
    check("R6 pwm 4Bh committed", actv(8'h4B), 8'h0F);
    wr1(8'h19, 8'h21);
    wr1(8'h29, 8'h22);
    wr1(8'h39, 8'h23);
    wr1(8'h55, 8'hC5);
    check("R6 pattern 2 committed", actv(8'h29), 8'h22);
    check("R6 pattern 1 untouched", actv(8'h19), 8'h00);
    check("R6 pattern 3 untouched", actv(8'h39), 8'h00);
    check("R6 pattern 2 enable kept", actv(8'h2C), 8'h01);
    wr1(8'h54, 8'hC5);
    check("R6 pattern 1 committed", actv(8'h19), 8'h21);
  endtask

  task automatic t_unlock();
    logic [7:0] d;
    wr1(8'h0C, 8'h07);
    rd1(8'h0C, d);
    check("R8 locked write ignored", d, 8'h00);
    wr1(8'h0B, 8'h11);
    wr1(8'h0C, 8'h03);
    rd1(8'h0C, d);
    check("R7 R8 wrong key keeps lock", d, 8'h00);
    wr1(8'h0B, 8'hA5);
    wr1(8'h0C, 8'h05);
    rd1(8'h0C, d);
    check("R8 unlocked write stored", d, 8'h05);
    check("R8 trim on active image", actv(8'h0C), 8'h05);
    wr1(8'h0C, 8'h06);
    rd1(8'h0C, d);
    check("R8 unlock consumed", d, 8'h05);
    rd1(8'h0B, d);
    check("R7 unlock reg reads zero", d, 8'h00);
  endtask

  task automatic t_abort();
    logic k1, k2, k3;
    bus_start();
    put_byte(8'hE8, k1);
    put_byte(8'h08, k1);
    put_bits(8'hF0, 4);
    bus_stop();
    check("R11 stop mid-byte no write", actv(8'h08), 8'h00);
    bus_start();
    put_byte(8'hE8, k1);
    put_byte(8'h09, k1);
    put_bits(8'hFF, 5);
    bus_start();
    put_byte(8'hE8, k1);
    put_byte(8'h01, k2);
    put_byte(8'h44, k3);
    bus_stop();
    check("R11 start mid-byte no write", actv(8'h09), 8'h00);
    check("R11 recovered after restart", {7'd0, k1 & k2 & k3}, 8'd1);
    check("R11 recovered write lands", actv(8'h01), 8'h44);
  endtask

  task automatic t_shdn();
    logic k, a1, a2;
    logic [7:0] d;
    bus_start();
    put_byte(8'hE8, k);
    put_byte(8'h01, k);
    put_bits(8'h99, 4);
    shdn_n = 1'b0; qtr();
    shdn_n = 1'b1; qtr();
    put_bits(8'h90, 4);
    get_ack(a1);
    put_byte(8'h77, a2);
    bus_stop();
    check("R12 engine idle after edge", {7'd0, a1 | a2}, 8'd0);
    check("R12 registers retained", actv(8'h01), 8'h44);
    check("R12 colour retained", actv(8'h10), 8'hAB);
    rd1(8'h01, d);
    check("R12 engine usable again", d, 8'h44);
  endtask

  task automatic t_softrst();
    logic [7:0] d;
    wr1(8'h5F, 8'h00);
    check("R7 wrong reset key ignored", actv(8'h10), 8'hAB);
    wr1(8'h5F, 8'hC5);
    check("R9 active colour cleared", actv(8'h10), 8'h00);
    check("R9 default 02h restored", actv(8'h02), 8'h1F);
    check("R9 plain reg cleared", actv(8'h01), 8'h00);
    check("R9 pattern enable restored", actv(8'h1C), 8'h01);
    rd1(8'h10, d);
    check("R9 staging cleared", d, 8'h00);
    rd1(8'h0C, d);
    check("R9 trim cleared", d, 8'h00);
    wr1(8'h0B, 8'hA5);
    wr1(8'h5F, 8'hC5);
    wr1(8'h0C, 8'h09);
    rd1(8'h0C, d);
    check("R9 lock re-armed", d, 8'h00);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    qtr();
    t_reset();
    t_strap();
    t_nack();
    t_burst();
    t_commit();
    t_unlock();
    t_abort();
    t_shdn();
    t_softrst();
    done = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual run still busy, expected completion");
      report();
      $finish;
    end
  end

endmodule